// File: doc/BRIEF.md
# Shared Page Map Address Translator

This block turns a 24-bit bus address into a physical board-memory address by looking it up in a writable page table. Two requesters use the same table: a network controller on the chip-side lookup port and the host processor on the host-side lookup port. The four most significant address bits carry no meaning and are dropped. From the remaining 20 bits, the upper ten pick one of 1024 table slots and the lower ten pass through unchanged as the byte offset inside a 1 KB page. A third port lets software load and inspect table slots 16 or 8 bits at a time.

Each slot holds three things. The first is a 12-bit physical frame number. The second is a flag that places the page either in onboard memory or on an auxiliary memory bus. The third is a byte-order flag. When that flag marks a page as little-endian, the two bytes of the 16-bit data word that travels with the lookup are exchanged. A slot has no valid or permission field, so every lookup returns a result. Several slots may name the same frame. This aliasing is how the top page of the 24-bit space, which holds the controller's fixed boot structure, is folded onto frame 0.

Both lookup ports share one read path of the table, so the block completes one lookup per cycle. A lookup returns its result one cycle after it is accepted. If both ports ask in the same cycle, the controller is served first and the host must hold its request.

Top module: `pagemap_xlate`

## Requirements
- R1: A synchronous active-high reset loads every slot i with the value 0x8000 | i. This makes the map an identity map with the host-order flag set. Reset also clears every valid output.
- R2: A lookup address is split as follows. Bits [23:20] are ignored. Bits [19:10] select the slot. Bits [9:0] appear unchanged as paddr[9:0], and paddr[21:10] is the slot's frame number. The result appears in the cycle after the request.
- R3: The slot format is fixed. Bit 15 is the host-order flag, bit 13 drives the aux output (1 means auxiliary bus, 0 means onboard), and bits [11:0] are the frame number. Bits 14 and 12 are stored and read back but change no lookup output.
- R4: If bit 15 of the selected slot is 0, the returned data word is the request's data word with bytes [15:8] and [7:0] exchanged. If bit 15 is 1, the word passes through unchanged.
- R5: No slot value can refuse a lookup. Every accepted request produces exactly one valid pulse one cycle later.
- R6: The controller port and the host port read the same table, so equal addresses give equal results.
- R7: When both ports request in the same cycle, the controller is served and h_gnt is low. A host request that is held is served in a later cycle. c_vld and h_vld are never high together.
- R8: For a table write, reg_be[1] enables bits [15:8] and reg_be[0] enables bits [7:0]. A byte that is not enabled keeps its value.
- R9: A lookup issued in the same cycle as a write to its slot sees the old slot value. Any lookup issued in a later cycle sees the new value.
- R10: Two slots that hold the same frame number translate to the same physical page. For example, slot 1023 and slot 0 both set to frame 0 map 0xFFFFF4 and 0x0003F4 to the same address.
- R11: A register read returns the addressed slot on reg_rdata, with reg_rvld high, in the cycle after reg_rd. When a read and a write to the same slot happen in the same cycle, the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Table write strobe |
| reg_rd | input | 1 | Table read strobe |
| reg_idx | input | 10 | Slot number for a read or write |
| reg_wdata | input | 16 | Write data |
| reg_be | input | 2 | Byte enables: bit 1 for the upper byte, bit 0 for the lower byte |
| reg_rdata | output | 16 | Read data |
| reg_rvld | output | 1 | Read data valid |
| c_req | input | 1 | Controller lookup request |
| c_addr | input | 24 | Controller address |
| c_wdata | input | 16 | Controller data word |
| c_vld | output | 1 | Controller result valid |
| c_paddr | output | 22 | Controller physical address |
| c_aux | output | 1 | Controller page is on the auxiliary bus |
| c_rdata | output | 16 | Controller data word after lane ordering |
| h_req | input | 1 | Host lookup request |
| h_addr | input | 24 | Host address |
| h_wdata | input | 16 | Host data word |
| h_gnt | output | 1 | Host request accepted this cycle |
| h_vld | output | 1 | Host result valid |
| h_paddr | output | 22 | Host physical address |
| h_aux | output | 1 | Host page is on the auxiliary bus |
| h_rdata | output | 16 | Host data word after lane ordering |

## Verification
The first lookups run against the identity map after reset, using addresses whose top nibble differs. This separates the 4 bits that are dropped from the 10 index bits. Slots are then loaded with mixed flag and frame values, including full-word writes, single-byte writes and writes to the reserved bits. The resulting lookups show whether the frame, the aux flag and the byte-order flag each come from the correct bit. Two timing cases are tested. A write and a lookup to the same slot in the same cycle checks that old and new contents are kept apart. Simultaneous requests from both ports check who wins the shared read path. A final run of random mixed traffic is compared on every clock against a behavioural model of the table.

// File: rtl/pgx_pkg.sv
`timescale 1ns/1ps
package pgx_pkg;
    localparam int ADDR_W  = 24;
    localparam int IDX_W   = 10;
    localparam int OFFS_W  = 10;
    localparam int PFN_W   = 12;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int ENT_W   = 16;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int PADDR_W = PFN_W + OFFS_W;

    // slot layout: host-order flag, reserved, aux-bus flag, reserved, frame
    typedef struct packed {
        logic             native;
        logic             rsv_hi;
        logic             aux;
        logic             rsv_lo;
        logic [PFN_W-1:0] pfn;
    } map_ent_t;

    typedef enum logic {SRC_CHIP = 1'b0, SRC_HOST = 1'b1} src_e;

    typedef struct packed {
        src_e              src;
        logic [IDX_W-1:0]  idx;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] data;
    } lookup_t;

    typedef struct packed {
        src_e              src;
        map_ent_t          ent;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] data;
    } result_t;

    function automatic map_ent_t ident_ent(int i);
        map_ent_t e;
        e        = '0;
        e.native = 1'b1;
        e.pfn    = PFN_W'(i);
        return e;
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
        return a[OFFS_W +: IDX_W];
    endfunction

    function automatic logic [OFFS_W-1:0] offs_of(logic [ADDR_W-1:0] a);
        return a[OFFS_W-1:0];
    endfunction
endpackage

// File: rtl/pgx_arbiter.sv
`timescale 1ns/1ps
module pgx_arbiter
    import pgx_pkg::*;
(
    input  logic              c_req,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    input  logic              h_req,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_gnt,
    output logic              lk_vld,
    output lookup_t           lk
);
    // controller wins the single table read path
    always_comb begin
        h_gnt  = h_req & ~c_req;
        lk_vld = c_req | h_req;
        if (c_req) begin
            lk.src  = SRC_CHIP;
            lk.idx  = idx_of(c_addr);
            lk.offs = offs_of(c_addr);
            lk.data = c_wdata;
        end else begin
            lk.src  = SRC_HOST;
            lk.idx  = idx_of(h_addr);
            lk.offs = offs_of(h_addr);
            lk.data = h_wdata;
        end
    end
endmodule

// File: rtl/pgx_map_store.sv
`timescale 1ns/1ps
module pgx_map_store
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [IDX_W-1:0] idx,
    input  logic [ENT_W-1:0] wdata,
    input  logic [LANES-1:0] be,
    output logic [ENT_W-1:0] rdata,
    output logic             rvld,
    input  logic             lk_vld,
    input  lookup_t          lk,
    output logic             res_vld,
    output result_t          res
);
    map_ent_t map_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) map_q[i] <= ident_ent(i);
            rvld    <= 1'b0;
            rdata   <= '0;
            res_vld <= 1'b0;
            res     <= '0;
        end else begin
            rvld <= rd;
            if (rd) rdata <= map_q[idx];
            res_vld <= lk_vld;
            if (lk_vld) begin
                res.src  <= lk.src;
                res.ent  <= map_q[lk.idx];
                res.offs <= lk.offs;
                res.data <= lk.data;
            end
            if (wr) begin
                for (int b = 0; b < LANES; b++)
                    if (be[b]) map_q[idx][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
        rvld |-> $past(rd));
    p_every_lookup_answers_r5: assert property (@(posedge clk) disable iff (rst)
        lk_vld |=> res_vld);
    p_no_phantom_result_r5: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $past(lk_vld));
endmodule

// File: rtl/pgx_lane_swap.sv
`timescale 1ns/1ps
module pgx_lane_swap #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NL = DW / BW;
    for (genvar j = 0; j < NL; j++) begin : g_lane
        assign dout[j*BW +: BW] = en ? din[(NL-1-j)*BW +: BW] : din[j*BW +: BW];
    end
endmodule

// File: rtl/pagemap_xlate.sv
`timescale 1ns/1ps
module pagemap_xlate
    import pgx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [ENT_W-1:0]   reg_wdata,
    input  logic [LANES-1:0]   reg_be,
    output logic [ENT_W-1:0]   reg_rdata,
    output logic               reg_rvld,
    input  logic               c_req,
    input  logic [ADDR_W-1:0]  c_addr,
    input  logic [DATA_W-1:0]  c_wdata,
    output logic               c_vld,
    output logic [PADDR_W-1:0] c_paddr,
    output logic               c_aux,
    output logic [DATA_W-1:0]  c_rdata,
    input  logic               h_req,
    input  logic [ADDR_W-1:0]  h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic               h_gnt,
    output logic               h_vld,
    output logic [PADDR_W-1:0] h_paddr,
    output logic               h_aux,
    output logic [DATA_W-1:0]  h_rdata
);
    localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((1 << OFFS_W) - 1);

    logic              lk_vld;
    lookup_t           lk;
    logic              res_vld;
    result_t           res;
    logic [DATA_W-1:0] lane_out;
    logic [PADDR_W-1:0] paddr;

    pgx_arbiter u_arb (
        .c_req(c_req), .c_addr(c_addr), .c_wdata(c_wdata),
        .h_req(h_req), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_gnt(h_gnt), .lk_vld(lk_vld), .lk(lk)
    );

    pgx_map_store u_store (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .idx(reg_idx),
        .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata), .rvld(reg_rvld),
        .lk_vld(lk_vld), .lk(lk), .res_vld(res_vld), .res(res)
    );

    pgx_lane_swap #(.DW(DATA_W), .BW(BYTE_W)) u_swap (
        .en(~res.ent.native), .din(res.data), .dout(lane_out)
    );

    assign paddr   = {res.ent.pfn, res.offs};
    assign c_vld   = res_vld & (res.src == SRC_CHIP);
    assign h_vld   = res_vld & (res.src == SRC_HOST);
    assign c_paddr = paddr;
    assign h_paddr = paddr;
    assign c_aux   = res.ent.aux;
    assign h_aux   = res.ent.aux;
    assign c_rdata = lane_out;
    assign h_rdata = lane_out;

    p_chip_served_r7: assert property (@(posedge clk) disable iff (rst)
        c_req |=> c_vld);
    p_host_served_r7: assert property (@(posedge clk) disable iff (rst)
        (h_req && !c_req) |=> h_vld);
    p_single_winner_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({c_vld, h_vld}));
    p_offset_kept_c_r2: assert property (@(posedge clk) disable iff (rst)
        c_vld |-> ({{(ADDR_W-OFFS_W){1'b0}}, c_paddr[OFFS_W-1:0]} == $past(c_addr & OFFS_MASK)));
    p_offset_kept_h_r2: assert property (@(posedge clk) disable iff (rst)
        h_vld |-> ({{(ADDR_W-OFFS_W){1'b0}}, h_paddr[OFFS_W-1:0]} == $past(h_addr & OFFS_MASK)));
endmodule

// File: tb/pagemap_xlate_test.sv
`timescale 1ns/1ps
module pagemap_xlate_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [9:0]  reg_idx = 0;
    logic [15:0] reg_wdata = 0;
    logic [1:0]  reg_be = 0;
    logic [15:0] reg_rdata;
    logic        reg_rvld;
    logic        c_req = 0, h_req = 0;
    logic [23:0] c_addr = 0, h_addr = 0;
    logic [15:0] c_wdata = 0, h_wdata = 0;
    logic        c_vld, h_vld, c_aux, h_aux, h_gnt;
    logic [21:0] c_paddr, h_paddr;
    logic [15:0] c_rdata, h_rdata;

    pagemap_xlate uut (.*);

    int    n_chk = 0, n_err = 0;
    bit    run = 0, done = 0;
    string cur_req = "R1";

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // behavioural reference
    logic [15:0] mm [1024];
    logic        e_rvld = 0, e_cvld = 0, e_hvld = 0, e_caux, e_haux;
    logic [15:0] e_rdata, e_cdata, e_hdata;
    logic [21:0] e_cpa, e_hpa;

    function automatic void xl(input logic [23:0] a, input logic [15:0] w,
                               output logic [21:0] pa, output logic aux, output logic [15:0] d);
        logic [15:0] ent;
        ent = mm[a[19:10]];
        pa  = {ent[11:0], a[9:0]};
        aux = ent[13];
        d   = ent[15] ? w : {w[7:0], w[15:8]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mm[i] = 16'h8000 | 16'(i);
            e_rvld = 0; e_cvld = 0; e_hvld = 0;
        end else begin
            e_rvld = reg_rd;
            if (reg_rd) e_rdata = mm[reg_idx];
            e_cvld = c_req;
            e_hvld = h_req && !c_req;
            if (c_req) xl(c_addr, c_wdata, e_cpa, e_caux, e_cdata);
            if (e_hvld) xl(h_addr, h_wdata, e_hpa, e_haux, e_hdata);
            if (reg_wr) begin
                if (reg_be[0]) mm[reg_idx][7:0]  = reg_wdata[7:0];
                if (reg_be[1]) mm[reg_idx][15:8] = reg_wdata[15:8];
            end
        end
    end

    always @(negedge clk) if (run) begin
        chk(cur_req, "model reg_rvld", reg_rvld, e_rvld);
        if (e_rvld) chk(cur_req, "model reg_rdata", reg_rdata, e_rdata);
        chk(cur_req, "model c_vld", c_vld, e_cvld);
        chk(cur_req, "model h_vld", h_vld, e_hvld);
        if (e_cvld) begin
            chk(cur_req, "model c_paddr", c_paddr, e_cpa);
            chk(cur_req, "model c_aux", c_aux, e_caux);
            chk(cur_req, "model c_rdata", c_rdata, e_cdata);
        end
        if (e_hvld) begin
            chk(cur_req, "model h_paddr", h_paddr, e_hpa);
            chk(cur_req, "model h_aux", h_aux, e_haux);
            chk(cur_req, "model h_rdata", h_rdata, e_hdata);
        end
    end

    task automatic wr(input logic [9:0] i, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk); reg_wr = 1; reg_idx = i; reg_wdata = d; reg_be = be;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rdchk(string rq, input logic [9:0] i, input logic [15:0] exp);
        @(negedge clk); reg_rd = 1; reg_idx = i;
        @(negedge clk); reg_rd = 0;
        chk(rq, "reg_rvld", reg_rvld, 1);
        chk(rq, "reg_rdata", reg_rdata, exp);
    endtask

    task automatic clook(string rq, input logic [23:0] a, input logic [15:0] w,
                         input logic [21:0] epa, input logic eaux, input logic [15:0] ed);
        @(negedge clk); c_req = 1; c_addr = a; c_wdata = w;
        @(negedge clk); c_req = 0;
        chk(rq, "c_vld", c_vld, 1);
        chk(rq, "c_paddr", c_paddr, epa);
        chk(rq, "c_aux", c_aux, eaux);
        chk(rq, "c_rdata", c_rdata, ed);
    endtask

    task automatic hlook(string rq, input logic [23:0] a, input logic [15:0] w,
                         input logic [21:0] epa, input logic eaux, input logic [15:0] ed);
        @(negedge clk); h_req = 1; h_addr = a; h_wdata = w;
        @(negedge clk); h_req = 0;
        chk(rq, "h_vld", h_vld, 1);
        chk(rq, "h_paddr", h_paddr, epa);
        chk(rq, "h_aux", h_aux, eaux);
        chk(rq, "h_rdata", h_rdata, ed);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        run = 1;
        // R1: reset state and identity map
        cur_req = "R1";
        chk("R1", "c_vld after reset", c_vld, 0);
        chk("R1", "h_vld after reset", h_vld, 0);
        chk("R1", "reg_rvld after reset", reg_rvld, 0);
        rdchk("R1", 10'd0, 16'h8000);
        rdchk("R1", 10'd5, 16'h8005);
        rdchk("R1", 10'd1023, 16'h83FF);
        // R2: address split, top nibble dropped
        cur_req = "R2";
        clook("R2", 24'hA12345, 16'h1234, 22'h12345, 0, 16'h1234);
        clook("R2", 24'h512345, 16'h1234, 22'h12345, 0, 16'h1234);
        // R3 and R4: frame, aux and swap taken from the slot
        cur_req = "R3";
        wr(10'h48, 16'h2ABC, 2'b11);
        clook("R3", 24'h012345, 16'h1234, 22'h2AF345, 1, 16'h3412);
        cur_req = "R4";
        clook("R4", 24'h012345, 16'hBEEF, 22'h2AF345, 1, 16'hEFBE);
        // R6: host sees same slot
        cur_req = "R6";
        hlook("R6", 24'hF12345, 16'h1234, 22'h2AF345, 1, 16'h3412);
        // R8: byte-enabled writes
        cur_req = "R8";
        wr(10'h48, 16'h80FF, 2'b10);
        rdchk("R8", 10'h48, 16'h80BC);
        clook("R8", 24'h012345, 16'h1234, 22'h02F345, 0, 16'h1234);
        wr(10'h48, 16'h0011, 2'b01);
        rdchk("R8", 10'h48, 16'h8011);
        // R3: reserved bits stored but inert
        cur_req = "R3";
        wr(10'd7, 16'hD007, 2'b11);
        rdchk("R3", 10'd7, 16'hD007);
        clook("R3", 24'h001C01, 16'h55AA, 22'h001C01, 0, 16'h55AA);
        // R9: write and lookup to the same slot in one cycle
        cur_req = "R9";
        @(negedge clk);
        reg_wr = 1; reg_idx = 10'd3; reg_wdata = 16'h8100; reg_be = 2'b11;
        c_req = 1; c_addr = 24'h000C10; c_wdata = 16'h0001;
        @(negedge clk);
        reg_wr = 0;
        chk("R9", "same-cycle lookup sees old slot", c_paddr, 22'h000C10);
        @(negedge clk);
        c_req = 0;
        chk("R9", "next lookup sees new slot", c_paddr, 22'h040010);
        // R11: read and write same slot same cycle returns old
        cur_req = "R11";
        @(negedge clk);
        reg_wr = 1; reg_rd = 1; reg_idx = 10'd9; reg_wdata = 16'h0123; reg_be = 2'b11;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        chk("R11", "read beside write gives old", reg_rdata, 16'h8009);
        rdchk("R11", 10'd9, 16'h0123);
        // R7: both ports at once
        cur_req = "R7";
        @(negedge clk);
        c_req = 1; c_addr = 24'h000420; h_req = 1; h_addr = 24'h000830;
        #1 chk("R7", "h_gnt while controller asks", h_gnt, 0);
        @(negedge clk);
        chk("R7", "controller served", c_vld, 1);
        chk("R7", "host held", h_vld, 0);
        chk("R7", "controller paddr", c_paddr, 22'h000420);
        c_req = 0;
        #1 chk("R7", "h_gnt when alone", h_gnt, 1);
        @(negedge clk);
        h_req = 0;
        chk("R7", "host served later", h_vld, 1);
        chk("R7", "host paddr", h_paddr, 22'h000830);
        chk("R7", "controller idle", c_vld, 0);
        // R10: aliasing top slot onto frame 0
        cur_req = "R10";
        wr(10'd1023, 16'h8000, 2'b11);
        clook("R10", 24'hFFFFF4, 16'h0000, 22'h0003F4, 0, 16'h0000);
        clook("R10", 24'h0003F4, 16'h0000, 22'h0003F4, 0, 16'h0000);
        // R5: mixed random traffic against the model
        cur_req = "R5";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            c_req = ($urandom % 3) == 0; h_req = ($urandom % 2) == 0;
            c_addr = 24'($urandom); h_addr = 24'($urandom);
            c_wdata = 16'($urandom); h_wdata = 16'($urandom);
            reg_wr = ($urandom % 4) == 0; reg_rd = ($urandom % 4) == 0;
            reg_idx = 10'($urandom % 16); reg_wdata = 16'($urandom); reg_be = 2'($urandom);
            c_addr[19:14] = 6'($urandom % 2); h_addr[19:14] = 6'($urandom % 2);
        end
        @(negedge clk);
        c_req = 0; h_req = 0; reg_wr = 0; reg_rd = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule